// File: doc/BRIEF.md
# Lookup-Table Multiply-Accumulate Unit

This block computes dot products for quantized neural-network inference without any hardware multiplier. Every weight and every activation is a 4-bit cluster code rather than an arithmetic value. For each operand pair, the weight code and the activation code are joined into an 8-bit address. That address selects one signed 16-bit entry in a 256-entry product table, which was filled with precomputed products before inference began. The fetched entries are summed into a signed 32-bit accumulator.

The same table serves every layer and channel, so software loads it once through a simple write port while the unit has no dot product in flight. Operand pairs then stream in over a valid/ready handshake. A last flag marks the final pair of each vector. The finished sum is presented with a one-cycle valid pulse, and the following vector may start in the very next cycle.

Top module: `lut_mac`

## Requirements
- R1: The table address for a pair is {weight code, activation code}: the weight code is bits 7:4 and the activation code is bits 3:0. The entry is a signed 16-bit product, and it is sign-extended before it is added.
- R2: A result equals the sum of the table entries of every pair accepted since the previous closing pair, up to and including the pair that carries the last flag.
- R3: The result valid pulse is high in the second cycle after the cycle in which the pair with the last flag is accepted, and at no other time.
- R4: While no table write is applied, in_ready is high every cycle. Consecutive vectors may therefore be streamed with no idle cycle, and each result excludes the pairs of the previous vector.
- R5: A vector of a single pair (last flag on its first pair) yields exactly that pair's table entry.
- R6: A table write issued while no vector is open and no pair is in the pipeline is stored. In that cycle in_ready is low.
- R7: A table write issued while a vector is open or a pair is still in the pipeline is ignored, and the table entry keeps its old value.
- R8: Synchronous active-high reset clears the result valid, the result value and the running sum, and leaves the table contents unchanged.
- R9: The result value holds steady between valid pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | 8 | Table write address {weight code, activation code} |
| tbl_data | input | 16 | Signed product to store |
| in_valid | input | 1 | Operand pair valid |
| in_ready | output | 1 | Unit can take a pair this cycle |
| in_wcode | input | 4 | Weight cluster code |
| in_acode | input | 4 | Activation cluster code |
| in_last | input | 1 | Pair closes the current dot product |
| out_valid | output | 1 | One-cycle pulse: out_sum holds a new result |
| out_sum | output | 32 | Signed dot-product result |

## Verification
A pair accepted in cycle N has its table entry registered by cycle N+1. If that pair closes its vector, the result pulse is due in cycle N+2. The bench drives inputs just after each rising edge and samples at the falling edge, where it keeps a cycle count. When it sees an accepted closing pair, it queues both the reference sum and the due cycle N+2. When a pulse appears, it compares the pulse's cycle and its value with the oldest queue entry. In every cycle with no pulse, the bench checks that out_sum has not moved. After each table write, the effect is checked through single-pair vectors whose results arrive two cycles after they are accepted.

// File: rtl/lut_mac.sv
module lut_mac #(
  parameter int CODE_W = 4,
  parameter int PROD_W = 16,
  parameter int ACC_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tbl_we,
  input  logic [2*CODE_W-1:0]      tbl_addr,
  input  logic [PROD_W-1:0]        tbl_data,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [CODE_W-1:0]        in_wcode,
  input  logic [CODE_W-1:0]        in_acode,
  input  logic                     in_last,
  output logic                     out_valid,
  output logic [ACC_W-1:0]         out_sum
);

  localparam int ADDR_W = 2 * CODE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [PROD_W-1:0] mem [DEPTH];
  logic              open_q;
  logic              s1_v, s1_last;
  logic [PROD_W-1:0] s1_prod;
  logic [ACC_W-1:0]  acc, prod_ext, sum_next;
  logic              busy, accept, wr_ok;

  assign busy     = open_q | s1_v;
  assign wr_ok    = tbl_we & ~busy;
  assign in_ready = ~rst & ~wr_ok;
  assign accept   = in_valid & in_ready;
  assign prod_ext = {{(ACC_W-PROD_W){s1_prod[PROD_W-1]}}, s1_prod};
  assign sum_next = acc + prod_ext;

  always_ff @(posedge clk)
    if (wr_ok) mem[tbl_addr] <= tbl_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q  <= 1'b0;
      s1_v    <= 1'b0;
      s1_last <= 1'b0;
      s1_prod <= '0;
    end else begin
      s1_v    <= accept;
      s1_last <= accept & in_last;
      if (accept) begin
        open_q  <= ~in_last;
        s1_prod <= mem[{in_wcode, in_acode}];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      out_sum   <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= s1_v & s1_last;
      if (s1_v) begin
        if (s1_last) begin
          acc     <= '0;
          out_sum <= sum_next;
        end else begin
          acc <= sum_next;
        end
      end
    end
  end

  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_last) |=> ##1 out_valid); // R3

  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid && in_ready && in_last, 2)); // R3

  AST_SUM_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_sum)); // R9

  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (tbl_we && busy) |=> mem[$past(tbl_addr)] == $past(mem[tbl_addr])); // R7

  AST_READY_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (rst)
    !tbl_we |-> in_ready); // R4

endmodule

// File: tb/sim_lut_mac.sv
module sim_lut_mac;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tbl_we = 1'b0;
  logic [7:0]  tbl_addr = '0;
  logic [15:0] tbl_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_wcode = '0, in_acode = '0;
  logic        in_last = 1'b0;
  logic        out_valid;
  logic [31:0] out_sum;

  lut_mac u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0, wr_apply = 0;
  logic [15:0] shadow [256];
  logic [31:0] run = '0, last_seen = '0;
  logic [31:0] exp_q [$];
  int          due_q [$];

  function automatic logic [31:0] sext(input logic [15:0] p);
    return {{16{p[15]}}, p};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (rst) begin
      run = '0; exp_q.delete(); due_q.delete();
    end else begin
      if (out_valid) begin
        if (exp_q.size() == 0) check(0, "R3 stray pulse", 1, 0);
        else begin
          check(due_q[0] == cyc, "R3 latency", cyc, due_q[0]);
          check(out_sum == exp_q[0], "R2 sum", out_sum, exp_q[0]);
          void'(exp_q.pop_front()); void'(due_q.pop_front());
        end
        last_seen = out_sum;
      end else begin
        check(out_sum == last_seen, "R9 hold", out_sum, last_seen);
      end
      if (tbl_we && wr_apply) begin
        check(in_ready == 1'b0, "R6 ready low on write", in_ready, 0);
        shadow[tbl_addr] = tbl_data;
      end
      if (in_valid && !wr_apply) check(in_ready == 1'b1, "R4 ready", in_ready, 1);
      if (in_valid && in_ready) begin
        run = run + sext(shadow[{in_wcode, in_acode}]);
        if (in_last) begin
          exp_q.push_back(run); due_q.push_back(cyc + 2); run = '0;
        end
      end
    end
  end

  task automatic step(); @(posedge clk); #1; endtask

  task automatic write_idle(input logic [7:0] a, input logic [15:0] d);
    tbl_we = 1; tbl_addr = a; tbl_data = d; wr_apply = 1;
    step();
    tbl_we = 0; wr_apply = 0;
  endtask

  task automatic drain(); repeat (4) step(); endtask

  task automatic send_vec(input int len, input bit gaps, input bit busy_wr);
    for (int i = 0; i < len; i++) begin
      if (gaps && ($urandom % 4 == 0)) begin in_valid = 0; step(); end
      in_valid = 1; in_wcode = 4'($urandom); in_acode = 4'($urandom);
      in_last = (i == len - 1);
      if (busy_wr && i >= 1 && ($urandom % 2 == 0)) begin
        tbl_we = 1; tbl_addr = 8'($urandom); tbl_data = 16'($urandom);
      end
      step();
      tbl_we = 0;
    end
    in_valid = 0; in_last = 0;
  endtask

  task automatic single(input logic [3:0] w, input logic [3:0] a);
    in_valid = 1; in_wcode = w; in_acode = a; in_last = 1;
    step();
    in_valid = 0; in_last = 0;
  endtask

  task automatic do_reset();
    rst = 1; step(); step();
    check(out_valid == 0, "R8 valid cleared", out_valid, 0);
    check(out_sum == 0, "R8 sum cleared", out_sum, 0);
    last_seen = '0;
    rst = 0; step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    step();
    do_reset();
    for (int i = 0; i < 256; i++) write_idle(8'(i), 16'($urandom));
    // R1: orientation and sign of the entry
    write_idle(8'h35, 16'sd1234);
    write_idle(8'h53, -16'sd77);
    single(4'h3, 4'h5); drain();
    single(4'h5, 4'h3); drain();
    // R5: single-pair vectors back to back
    single(4'hF, 4'h0); single(4'h0, 4'hF); single(4'h3, 4'h5); drain();
    // R4: random back-to-back vectors
    for (int v = 0; v < 40; v++) send_vec(1 + $urandom % 20, 0, 0);
    drain();
    // R2: vectors with gaps
    for (int v = 0; v < 20; v++) begin send_vec(1 + $urandom % 12, 1, 0); drain(); end
    // R7: busy writes ignored, then probe old entries
    for (int v = 0; v < 20; v++) send_vec(2 + $urandom % 10, 0, 1);
    drain();
    for (int k = 0; k < 16; k++) single(4'(k), 4'(15 - k));
    drain();
    // R1: most negative entries, long vector
    for (int i = 0; i < 16; i++) write_idle({4'h7, 4'(i)}, 16'h8000);
    in_valid = 1; in_wcode = 4'h7;
    for (int i = 0; i < 300; i++) begin
      in_acode = 4'($urandom); in_last = (i == 299); step();
    end
    in_valid = 0; in_last = 0; drain();
    // R8: reset mid-vector keeps table, clears running sum
    send_vec(5, 0, 0);
    in_valid = 1; in_wcode = 4'h2; in_acode = 4'h9; in_last = 0; step(); step();
    in_valid = 0;
    do_reset();
    single(4'h3, 4'h5); drain();
    for (int v = 0; v < 10; v++) send_vec(1 + $urandom % 8, 1, 0);
    drain();
    check(exp_q.size() == 0, "R3 missing pulses", exp_q.size(), 0);
    finish_run();
  end
endmodule